// File: doc/BRIEF.md
# Segmented Packet Bus Width Upsizer

This block takes a narrow segmented packet stream, with two 64-bit segments per beat, and repacks it into a wide segmented stream with four 128-bit segments per beat. Every segment on either side has its own enable, start flag, end flag, error flag and empty-byte count. The block works in 64-bit halves. It writes each enabled input segment into the next free half of an output beat that it is filling. A packet therefore always begins at the first byte of output segment 0, and no output segment ever holds bytes from two packets.

When one packet ends in input segment 0 and the next packet starts in input segment 1 of the same beat, the new packet falls half a wide segment out of step with the input beats. Because the block packs by halves, every later beat of that packet stays straddled across output segment boundaries until the packet's end flag arrives. An output beat leaves the block as soon as all eight halves are filled or a packet ends. A two-entry output queue absorbs the case where one input beat completes two output beats. The input side follows a valid/ready handshake and so does the output side.

Input contract: input segment 1 is enabled only when segment 0 is enabled. A start flag arrives only when no packet is part-way through.

Top module: `seg_bus_upsizer`

## Requirements
- R1: In an accepted input beat (in_valid and in_ready both high), each enabled segment is consumed in order, segment 0 first. Segment i occupies in_data[64*i+63:64*i]. Byte 0 of a packet is in the most significant byte lane.
- R2: Consumed halves fill output halves in arrival order. Output segment s occupies out_data[128*s+127:128*s]. The earlier half goes to bits [127:64] of a segment and the later half to bits [63:0]. Halves that are not filled read as zero.
- R3: Every output beat that holds a packet's first half asserts out_sop on segment 0 only. That packet's data starts at bit 127 of segment 0.
- R4: An output beat is produced when its eighth half is filled or when a half carrying an end flag is consumed. It becomes valid in the cycle after that input beat is accepted. Its enables are contiguous from segment 0. It carries at most one end flag, and that flag is on its highest enabled segment.
- R5: On the end segment, out_mty equals the input empty count plus 8 when the final half lies in bits [127:64], and equals the input empty count otherwise. On all other segments out_mty is 0.
- R6: The error flag of the input end segment appears on the output end segment. out_err is 0 on every other segment.
- R7: An input beat that ends a packet in segment 0 and starts a packet in segment 1 is accepted, and it can yield two output beats.
- R8: in_ready is 1 when no output beat is queued, or when exactly one is queued and out_ready is 1. It is 0 otherwise, and in particular while out_valid is 1 and out_ready is 0.
- R9: While out_valid is high and out_ready is low, the output beat holds steady. Every beat is delivered exactly once, in order.
- R10: While rst_n is low, out_valid is 0 and in_ready is 1. Any partly filled beat is discarded, so the first packet after reset is packed from half 0.
- R11: A packet that starts in input segment 1 keeps its half-segment offset on every later output beat until its end flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat offered |
| in_ready | output | 1 | Input beat can be taken |
| in_data | input | 128 | Two 64-bit input segments |
| in_ena | input | 2 | Per-segment enable |
| in_sop | input | 2 | Per-segment start of packet |
| in_eop | input | 2 | Per-segment end of packet |
| in_err | input | 2 | Per-segment error |
| in_mty | input | 6 | Per-segment empty-byte count, 3 bits each |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Output beat taken |
| out_data | output | 512 | Four 128-bit output segments |
| out_ena | output | 4 | Per-segment enable |
| out_sop | output | 4 | Per-segment start of packet |
| out_eop | output | 4 | Per-segment end of packet |
| out_err | output | 4 | Per-segment error |
| out_mty | output | 16 | Per-segment empty-byte count, 4 bits each |

## Verification
The hardest situation to reach is an input beat that completes two output beats at once while one beat is already queued. This happens when a full beat or an end in segment 0 is followed by a single-half packet in segment 1, and the queue then sits behind a stalled out_ready. The bench makes it happen with directed single-half packets placed back to back and a long packet that starts in the upper input segment. It then runs a long random mix of packet lengths, single-segment beats, idle cycles and out_ready dropping about a third of the time, so that a straddled packet runs into backpressure many times. A reset in the middle of a packet checks that no leftover halves leak into the next packet.

// File: rtl/seg_bus_upsizer.sv
module seg_bus_upsizer #(
  parameter int IW = 64,
  parameter int NO = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [2*IW-1:0]       in_data,
  input  logic [1:0]            in_ena,
  input  logic [1:0]            in_sop,
  input  logic [1:0]            in_eop,
  input  logic [1:0]            in_err,
  input  logic [2*$clog2(IW/8)-1:0] in_mty,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [NO*2*IW-1:0]    out_data,
  output logic [NO-1:0]         out_ena,
  output logic [NO-1:0]         out_sop,
  output logic [NO-1:0]         out_eop,
  output logic [NO-1:0]         out_err,
  output logic [NO*($clog2(IW/8)+1)-1:0] out_mty
);
  localparam int IMW = $clog2(IW/8);
  localparam int OMW = IMW + 1;
  localparam int NH  = 2 * NO;
  localparam int HW  = $clog2(NH);
  localparam int CW  = $clog2(NH + 1);

  typedef struct packed {
    logic [NH-1:0][IW-1:0] d;
    logic [CW-1:0]         cnt;
    logic                  sop;
  } acc_t;

  typedef struct packed {
    logic [NO-1:0][2*IW-1:0] d;
    logic [NO-1:0]           ena;
    logic [NO-1:0]           sop;
    logic [NO-1:0]           eop;
    logic [NO-1:0]           err;
    logic [NO-1:0][OMW-1:0]  mty;
  } beat_t;

  typedef struct packed {
    acc_t  a;
    logic  f;
    beat_t b;
  } step_t;

  function automatic beat_t mk_beat(acc_t a, logic e, logic r, logic [IMW-1:0] m);
    beat_t b;
    logic [CW-1:0] last;
    b = '0;
    last = (a.cnt - CW'(1)) >> 1;
    for (int s = 0; s < NO; s++) begin
      b.d[s]   = {a.d[2*s], a.d[2*s+1]};
      b.ena[s] = a.cnt > CW'(2*s);
      b.sop[s] = (s == 0) && a.sop;
      if (e && last == CW'(s)) begin
        b.eop[s] = 1'b1;
        b.err[s] = r;
        b.mty[s] = {a.cnt[0], m};
      end
    end
    return b;
  endfunction

  function automatic step_t step(acc_t a, logic v, logic [IW-1:0] x, logic s,
                                 logic e, logic r, logic [IMW-1:0] m);
    step_t o;
    o.a = a;
    o.f = 1'b0;
    o.b = '0;
    if (v) begin
      if (a.cnt == '0) o.a.sop = s;
      o.a.d[a.cnt[HW-1:0]] = x;
      o.a.cnt = a.cnt + CW'(1);
      if (e || o.a.cnt == CW'(NH)) begin
        o.f = 1'b1;
        o.b = mk_beat(o.a, e, r, m);
        o.a = '0;
      end
    end
    return o;
  endfunction

  acc_t  acc;
  beat_t q0, q1;
  logic  v0, v1;
  step_t s0, s1;
  logic  fire;

  assign in_ready = !v0 || (!v1 && out_ready);
  assign fire     = in_valid && in_ready;

  assign s0 = step(acc, fire && in_ena[0], in_data[0 +: IW], in_sop[0],
                   in_eop[0], in_err[0], in_mty[0 +: IMW]);
  assign s1 = step(s0.a, fire && in_ena[1], in_data[IW +: IW], in_sop[1],
                   in_eop[1], in_err[1], in_mty[IMW +: IMW]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0;
      q0  <= '0;
      q1  <= '0;
      v0  <= 1'b0;
      v1  <= 1'b0;
    end else begin
      acc <= s1.a;
      if (fire) begin
        v0 <= s0.f || s1.f;
        q0 <= s0.f ? s0.b : s1.b;
        v1 <= s0.f && s1.f;
        q1 <= s1.b;
      end else if (v0 && out_ready) begin
        v0 <= v1;
        q0 <= q1;
        v1 <= 1'b0;
      end
    end
  end

  assign out_valid = v0;
  assign out_data  = q0.d;
  assign out_ena   = q0.ena;
  assign out_sop   = q0.sop;
  assign out_eop   = q0.eop;
  assign out_err   = q0.err;
  assign out_mty   = q0.mty;
endmodule

module seg_bus_upsizer_props #(
  parameter int IW = 64,
  parameter int NO = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  in_ready,
  input logic                  out_valid,
  input logic                  out_ready,
  input logic [NO*2*IW-1:0]    out_data,
  input logic [NO-1:0]         out_ena,
  input logic [NO-1:0]         out_sop,
  input logic [NO-1:0]         out_eop,
  input logic [NO-1:0]         out_err,
  input logic [NO*($clog2(IW/8)+1)-1:0] out_mty
);
  localparam int OMW = $clog2(IW/8) + 1;

  assert_reset_idle_R10: assert property (@(posedge clk) !rst_n |=> !out_valid);

  assert_stall_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  assert_hold_beat_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_ena)
      && $stable(out_eop) && $stable(out_mty) && $stable(out_err) && $stable(out_sop));

  assert_sop_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_sop & ~NO'(1)) == '0);

  assert_one_eop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $countones(out_eop) <= 1);

  assert_contig_ena_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_ena[0] && ((out_ena & (out_ena + NO'(1))) == '0));

  assert_eop_is_tail_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_eop != '0 |-> ((out_eop - NO'(1)) | out_eop) == out_ena);

  for (genvar s = 0; s < NO; s++) begin : g_seg
    assert_mty_only_eop_R5: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_eop[s] |-> out_mty[s*OMW +: OMW] == '0);
    assert_err_only_eop_R6: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_eop[s] |-> !out_err[s]);
  end
endmodule

bind seg_bus_upsizer seg_bus_upsizer_props #(.IW(IW), .NO(NO)) props_i (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .out_ena(out_ena),
  .out_sop(out_sop), .out_eop(out_eop), .out_err(out_err), .out_mty(out_mty)
);

// File: tb/seg_bus_upsizer_tb_top.sv
`timescale 1ns/1ps
module seg_bus_upsizer_tb_top;
  localparam int IW = 64;
  localparam int NO = 4;
  localparam int BW = NO * 2 * IW;
  localparam int MW = NO * 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [2*IW-1:0] in_data = '0;
  logic [1:0] in_ena = '0, in_sop = '0, in_eop = '0, in_err = '0;
  logic [5:0] in_mty = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [BW-1:0] out_data;
  logic [NO-1:0] out_ena, out_sop, out_eop, out_err;
  logic [MW-1:0] out_mty;

  always #4 clk = ~clk;

  seg_bus_upsizer #(.IW(IW), .NO(NO)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_ena(in_ena), .in_sop(in_sop), .in_eop(in_eop),
    .in_err(in_err), .in_mty(in_mty), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_ena(out_ena), .out_sop(out_sop), .out_eop(out_eop),
    .out_err(out_err), .out_mty(out_mty)
  );

  int checks = 0, fails = 0, beats_seen = 0;
  bit done = 0, in_fire = 0, rdy_rand = 0;

  logic [IW-1:0] md[$];
  bit msop;
  logic [BW-1:0] e_data[$];
  logic [NO-1:0] e_ena[$], e_sop[$], e_eop[$], e_err[$];
  logic [MW-1:0] e_mty[$];

  logic [IW-1:0] sd[$];
  bit ss[$], se[$], sr[$];
  logic [2:0] sm[$];

  task automatic chk(bit ok, string req, logic [BW-1:0] got, logic [BW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at %0t: got %0h expected %0h", req, $time, got, exp);
    end
  endtask

  task automatic emit(bit e, bit r, logic [2:0] m);
    logic [BW-1:0] d = '0;
    logic [NO-1:0] en = '0, sp = '0, ep = '0, er = '0;
    logic [MW-1:0] my = '0;
    int n = md.size();
    int ls = (n - 1) / 2;
    for (int k = 0; k < n; k++) d[(k/2)*128 + ((k%2 == 0) ? 64 : 0) +: 64] = md[k];
    for (int s = 0; s < NO; s++) en[s] = (2*s < n);
    sp[0] = msop;
    if (e) begin
      ep[ls] = 1'b1;
      er[ls] = r;
      my[ls*4 +: 4] = (n % 2 == 1) ? 4'(m) + 4'd8 : 4'(m);
    end
    e_data.push_back(d); e_ena.push_back(en); e_sop.push_back(sp);
    e_eop.push_back(ep); e_err.push_back(er); e_mty.push_back(my);
    md.delete();
    msop = 0;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      #3;
      if (!rst_n) begin
        md.delete(); msop = 0; in_fire = 0;
        e_data.delete(); e_ena.delete(); e_sop.delete();
        e_eop.delete(); e_err.delete(); e_mty.delete();
        continue;
      end
      // R8: ready depends on queued beats and out_ready
      chk(in_ready == ((e_data.size() == 0) || (e_data.size() == 1 && out_ready)),
          "R8 in_ready", BW'(in_ready), BW'(!in_ready));
      // R4: a beat is valid the cycle after it is completed
      chk(out_valid == (e_data.size() != 0), "R4 out_valid", BW'(out_valid), BW'(e_data.size() != 0));
      if (out_valid && out_ready && e_data.size() != 0) begin
        beats_seen++;
        chk(out_data == e_data[0], "R2 data", out_data, e_data[0]);
        chk(out_ena  == e_ena[0],  "R4 ena",  BW'(out_ena), BW'(e_ena[0]));
        chk(out_sop  == e_sop[0],  "R3 sop",  BW'(out_sop), BW'(e_sop[0]));
        chk(out_eop  == e_eop[0],  "R4 eop",  BW'(out_eop), BW'(e_eop[0]));
        chk(out_mty  == e_mty[0],  "R5 mty",  BW'(out_mty), BW'(e_mty[0]));
        chk(out_err  == e_err[0],  "R6 err",  BW'(out_err), BW'(e_err[0]));
        void'(e_data.pop_front()); void'(e_ena.pop_front()); void'(e_sop.pop_front());
        void'(e_eop.pop_front()); void'(e_err.pop_front()); void'(e_mty.pop_front());
      end
      in_fire = in_valid && in_ready;
      if (in_fire) begin
        // R1: segment 0 is consumed before segment 1
        for (int i = 0; i < 2; i++) begin
          if (in_ena[i]) begin
            if (md.size() == 0) msop = in_sop[i];
            md.push_back(in_data[i*IW +: IW]);
            if (in_eop[i] || md.size() == 2*NO) emit(in_eop[i], in_err[i], in_mty[i*3 +: 3]);
          end
        end
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      out_ready = rdy_rand ? ($urandom % 100 < 65) : 1'b1;
    end
  end

  task automatic add_pkt(int n);
    for (int i = 0; i < n; i++) begin
      sd.push_back({$urandom, $urandom});
      ss.push_back(i == 0);
      se.push_back(i == n - 1);
      sr.push_back((i == n - 1) && ($urandom % 4 == 0));
      sm.push_back((i == n - 1) ? 3'($urandom % 8) : 3'd0);
    end
  endtask

  task automatic send(int k);
    @(negedge clk);
    in_valid = 1'b1;
    in_ena = '0; in_sop = '0; in_eop = '0; in_err = '0; in_mty = '0; in_data = '0;
    for (int i = 0; i < k; i++) begin
      in_data[i*IW +: IW] = sd.pop_front();
      in_ena[i] = 1'b1;
      in_sop[i] = ss.pop_front();
      in_eop[i] = se.pop_front();
      in_err[i] = sr.pop_front();
      in_mty[i*3 +: 3] = sm.pop_front();
    end
    do @(posedge clk); while (!in_fire);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
    @(posedge clk);
  endtask

  task automatic drain_stim(int one_pct, int idle_pct);
    while (sd.size() > 0) begin
      if ($urandom % 100 < idle_pct) idle();
      send((sd.size() > 1 && $urandom % 100 >= one_pct) ? 2 : 1);
    end
    idle();
  endtask

  task automatic settle();
    for (int i = 0; i < 200 && e_data.size() != 0; i++) @(posedge clk);
    repeat (3) @(posedge clk);
  endtask

  initial begin
    int base;
    repeat (3) @(posedge clk);
    #1;
    // R10: idle outputs during reset
    chk(out_valid == 1'b0, "R10 out_valid in reset", BW'(out_valid), '0);
    chk(in_ready == 1'b1, "R10 in_ready in reset", BW'(in_ready), BW'(1));
    @(negedge clk);
    rst_n = 1'b1;

    // R7 and R11: 3-half packet, then a 9-half packet starting in segment 1,
    // then two single-half packets sharing one input beat
    base = beats_seen;
    add_pkt(3); add_pkt(9); add_pkt(1); add_pkt(1);
    drain_stim(0, 0);
    settle();
    chk(beats_seen - base == 5, "R7 beat count", BW'(beats_seen - base), BW'(5));

    // R10: reset in the middle of a packet discards the partial beat
    add_pkt(6);
    send(2);
    idle();
    @(negedge clk);
    rst_n = 1'b0;
    sd.delete(); ss.delete(); se.delete(); sr.delete(); sm.delete();
    repeat (2) @(posedge clk);
    #1;
    chk(out_valid == 1'b0, "R10 out_valid after mid reset", BW'(out_valid), '0);
    @(negedge clk);
    rst_n = 1'b1;
    base = beats_seen;
    add_pkt(2);
    drain_stim(0, 0);
    settle();
    chk(beats_seen - base == 1, "R10 clean restart", BW'(beats_seen - base), BW'(1));

    // R9, R11: random lengths, single-segment beats, idles and stalls
    rdy_rand = 1;
    for (int p = 0; p < 500; p++) add_pkt(1 + $urandom % 20);
    drain_stim(20, 10);
    rdy_rand = 0;
    settle();
    // R9: nothing left undelivered
    chk(e_data.size() == 0, "R9 all beats delivered", BW'(e_data.size()), '0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R9 watchdog expired: got hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule